// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address that a synchronous burst memory array uses on each clock cycle. On every rising edge it samples a full external address, two active-low load strobes (one meant for a processor, one for a cache or memory controller), an active-low advance input, three chip enables, a write decode and a burst-order select. A strobe captures a new base address. Later cycles with advance asserted step the low address bits through a four-beat burst, in either linear or interleaved order. Cycles without advance keep the address where it is.

Every output is registered. The address, the cycle kind and the write flag that belong to the inputs sampled at an edge all appear together just after that edge. The cycle kind reports whether the memory is deselected, starting a burst, continuing a burst or holding a suspended burst. The array, data path and power control sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at an edge, the outputs after that edge are `addr_o` = 0, `kind_o` = 2'b00 (deselected) and `wr_o` = 0.
- R2: When `proc_strobe_n` = 0 and `en1_n` = 0, `addr_o` takes `addr_i`, `kind_o` = 2'b01 (burst start) and `wr_o` = 0, whatever `wr_req`, `en2` and `en3_n` are.
- R3: When both strobes are low and `en1_n` = 0, the processor-strobe rule of R2 applies and the controller strobe has no effect.
- R4: When `ctrl_strobe_n` = 0, R2 does not apply, and `en1_n` = 0, `en2` = 1 and `en3_n` = 0, `addr_o` takes `addr_i`, `kind_o` = 2'b01 and `wr_o` equals `wr_req`.
- R5: When `ctrl_strobe_n` = 0, R2 does not apply, and any enable is false, `kind_o` = 2'b00, `wr_o` = 0 and `addr_o` keeps its value.
- R6: A low `proc_strobe_n` while `en1_n` = 1 is ignored: the cycle behaves exactly as if that strobe were high.
- R7: With `order_il` = 0, successive advance cycles set the low two bits of `addr_o` to (base + n) mod 4 for n = 1, 2, 3, and the upper bits stay at the base.
- R8: With `order_il` = 1, successive advance cycles set the low two bits to base XOR n for n = 1, 2, 3.
- R9: The fourth advance after a load brings the low two bits back to the base value, and counting then repeats.
- R10: With no effective strobe and `adv_n` = 1 while a burst is open, `addr_o` holds and `kind_o` = 2'b11 (suspended).
- R11: With no effective strobe while deselected (after reset or R5), `kind_o` stays 2'b00 and `addr_o` holds, whatever `adv_n` is.
- R12: On an advance cycle of an open burst, `kind_o` = 2'b10 (continued). On advance and suspend cycles, `wr_o` equals `wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | External address captured by a strobe |
| proc_strobe_n | input | 1 | Processor load strobe, active low, always a read |
| ctrl_strobe_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | First chip enable, active low |
| en2 | input | 1 | Second chip enable, active high, used by controller strobe only |
| en3_n | input | 1 | Third chip enable, active low, used by controller strobe only |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_req | input | 1 | Write decode for the current cycle |
| addr_o | output | AW | Current array address |
| kind_o | output | 2 | Cycle kind: 00 deselect, 01 start, 10 continue, 11 suspend |
| wr_o | output | 1 | Current cycle is a write |

## Verification
The bench builds the block with a 6-bit address and the standard 2-bit burst field. This keeps every base offset and both burst orders within a short directed sweep, in which each offset is loaded and then advanced past the wrap point. A long pseudo-random run follows. It mixes the strobes, the enables, advance, order and write decode, so both strobes low together, an ignored processor strobe, and advance while deselected all occur many times. Each output is compared against a bench model that tracks base, step and open-burst state.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    K_IDLE  = 2'b00,
    K_START = 2'b01,
    K_RUN   = 2'b10,
    K_HOLD  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ACT_KEEP  = 2'b00,
    ACT_LOAD  = 2'b01,
    ACT_STEP  = 2'b10,
    ACT_DESEL = 2'b11
  } act_e;
endpackage

// File: rtl/bas_cycle_decode.sv
module bas_cycle_decode
  import bas_pkg::*;
(
  input  logic  proc_strobe_n,
  input  logic  ctrl_strobe_n,
  input  logic  adv_n,
  input  logic  en1_n,
  input  logic  en2,
  input  logic  en3_n,
  input  logic  wr_req,
  input  logic  open_q,
  output act_e  act,
  output kind_e kind,
  output logic  wr
);
  logic p_go, c_ok;

  assign p_go = !proc_strobe_n && !en1_n;
  assign c_ok = !en1_n && en2 && !en3_n;

  always_comb begin
    act  = ACT_KEEP;
    kind = K_IDLE;
    wr   = 1'b0;
    if (p_go) begin
      act  = ACT_LOAD;
      kind = K_START;
    end else if (!ctrl_strobe_n) begin
      if (c_ok) begin
        act  = ACT_LOAD;
        kind = K_START;
        wr   = wr_req;
      end else begin
        act  = ACT_DESEL;
      end
    end else if (!open_q) begin
      act  = ACT_KEEP;
    end else if (!adv_n) begin
      act  = ACT_STEP;
      kind = K_RUN;
      wr   = wr_req;
    end else begin
      act  = ACT_KEEP;
      kind = K_HOLD;
      wr   = wr_req;
    end
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
  parameter int BB = 2
) (
  input  logic [BB-1:0] base_lo,
  input  logic [BB-1:0] step,
  input  logic          interleave,
  output logic [BB-1:0] lo
);
  logic [BB-1:0] lin, xil;

  assign lin = base_lo + step;
  assign xil = base_lo ^ step;
  assign lo  = interleave ? xil : lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int AW = 8,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          proc_strobe_n,
  input  logic          ctrl_strobe_n,
  input  logic          adv_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          order_il,
  input  logic          wr_req,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    kind_o,
  output logic          wr_o
);
  localparam int HI_W = AW - BB;

  logic [AW-1:0] base_q, base_n;
  logic [BB-1:0] step_q, step_n;
  logic          open_q, open_n;
  logic [AW-1:0] addr_n;
  logic [BB-1:0] lo_n;
  act_e          act;
  kind_e         kind;
  logic          wr;

  bas_cycle_decode u_dec (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .en1_n         (en1_n),
    .en2           (en2),
    .en3_n         (en3_n),
    .wr_req        (wr_req),
    .open_q        (open_q),
    .act           (act),
    .kind          (kind),
    .wr            (wr)
  );

  always_comb begin
    base_n = base_q;
    step_n = step_q;
    open_n = open_q;
    case (act)
      ACT_LOAD: begin
        base_n = addr_i;
        step_n = '0;
        open_n = 1'b1;
      end
      ACT_STEP:  step_n = step_q + 1'b1;
      ACT_DESEL: open_n = 1'b0;
      default: ;
    endcase
  end

  bas_order_map #(.BB(BB)) u_map (
    .base_lo    (base_n[BB-1:0]),
    .step       (step_n),
    .interleave (order_il),
    .lo         (lo_n)
  );

  // Held cycles keep the presented address so a mode flip cannot move it.
  assign addr_n = (act == ACT_LOAD || act == ACT_STEP) ?
                  {base_n[AW-1:BB], lo_n} : addr_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
      open_q <= 1'b0;
      addr_o <= '0;
      kind_o <= K_IDLE;
      wr_o   <= 1'b0;
    end else begin
      base_q <= base_n;
      step_q <= step_n;
      open_q <= open_n;
      addr_o <= addr_n;
      kind_o <= kind;
      wr_o   <= wr;
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[AW-1:BB];
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 8,
  parameter int BB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic          proc_strobe_n,
  input logic          ctrl_strobe_n,
  input logic          adv_n,
  input logic          en1_n,
  input logic          en2,
  input logic          en3_n,
  input logic          wr_req,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    kind_o,
  input logic          wr_o
);
  logic p_go, no_stb;
  assign p_go   = !proc_strobe_n && !en1_n;
  assign no_stb = !p_go && ctrl_strobe_n;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && kind_o == 2'b00 && !wr_o));

  a_r2_proc_load: assert property (@(posedge clk) disable iff (rst)
    p_go |=> (addr_o == $past(addr_i) && kind_o == 2'b01 && !wr_o));

  a_r4_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (!p_go && !ctrl_strobe_n && !en1_n && en2 && !en3_n)
      |=> (addr_o == $past(addr_i) && kind_o == 2'b01 && wr_o == $past(wr_req)));

  a_r5_ctrl_desel: assert property (@(posedge clk) disable iff (rst)
    (!p_go && !ctrl_strobe_n && !(!en1_n && en2 && !en3_n))
      |=> (kind_o == 2'b00 && !wr_o && $stable(addr_o)));

  a_r10_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    (no_stb && adv_n && kind_o != 2'b00) |=> (kind_o == 2'b11 && $stable(addr_o)));

  a_r11_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (no_stb && kind_o == 2'b00) |=> (kind_o == 2'b00 && $stable(addr_o)));

  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (no_stb && !adv_n && kind_o != 2'b00)
      |=> (kind_o == 2'b10 && addr_o[AW-1:BB] == $past(addr_o[AW-1:BB])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .BB(BB)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .addr_i        (addr_i),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .adv_n         (adv_n),
  .en1_n         (en1_n),
  .en2           (en2),
  .en3_n         (en3_n),
  .wr_req        (wr_req),
  .addr_o        (addr_o),
  .kind_o        (kind_o),
  .wr_o          (wr_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 6;
  localparam int BB = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          sp_n, sc_n, adv_n, e1_n, e2, e3_n, il, wreq;
  logic [AW-1:0] addr_o;
  logic [1:0]    kind_o;
  logic          wr_o;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [AW-1:0] m_base, m_addr;
  logic [BB-1:0] m_step;
  logic          m_open, m_wr;
  logic [1:0]    m_kind;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW), .BB(BB)) u_dut (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .proc_strobe_n(sp_n), .ctrl_strobe_n(sc_n), .adv_n(adv_n),
    .en1_n(e1_n), .en2(e2), .en3_n(e3_n), .order_il(il), .wr_req(wreq),
    .addr_o(addr_o), .kind_o(kind_o), .wr_o(wr_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [BB-1:0] lo_of(input logic [BB-1:0] b,
                                          input logic [BB-1:0] s, input logic m);
    return m ? (b ^ s) : logic'(0) ? b : BB'((int'(b) + int'(s)) % 4);
  endfunction

  // One clock: inputs already driven; update model, then compare at negedge.
  task automatic tick();
    string tag, wtag;
    logic pg;
    @(posedge clk);
    pg = !sp_n && !e1_n;
    wtag = "";
    if (rst) begin
      m_base = '0; m_step = '0; m_open = 0; m_addr = '0; m_kind = 2'b00; m_wr = 0;
      tag = "R1";
    end else if (pg) begin
      m_base = addr_i; m_step = '0; m_open = 1; m_addr = addr_i;
      m_kind = 2'b01; m_wr = 0;
      tag = !sc_n ? "R3" : "R2";
    end else if (!sc_n) begin
      if (!e1_n && e2 && !e3_n) begin
        m_base = addr_i; m_step = '0; m_open = 1; m_addr = addr_i;
        m_kind = 2'b01; m_wr = wreq; tag = "R4";
      end else begin
        m_open = 0; m_kind = 2'b00; m_wr = 0; tag = "R5";
      end
    end else if (!m_open) begin
      m_kind = 2'b00; m_wr = 0;
      tag = (!sp_n) ? "R6" : "R11";
    end else if (!adv_n) begin
      m_step = m_step + 1'b1;
      m_addr = {m_base[AW-1:BB], lo_of(m_base[BB-1:0], m_step, il)};
      m_kind = 2'b10; m_wr = wreq;
      tag = (m_step == 0) ? "R9" : (il ? "R8" : "R7");
      wtag = "R12";
    end else begin
      m_kind = 2'b11; m_wr = wreq;
      tag = (!sp_n) ? "R6" : "R10";
      wtag = "R12";
    end
    if (wtag == "") wtag = tag;
    @(negedge clk);
    check(tag, "addr", addr_o, m_addr);
    check(tag, "kind", AW'(kind_o), AW'(m_kind));
    check(wtag, "wr", AW'(wr_o), AW'(m_wr));
  endtask

  task automatic drive(input logic r, input logic s_p, input logic s_c, input logic a,
                       input logic [AW-1:0] ad, input logic m, input logic w);
    rst = r; sp_n = s_p; sc_n = s_c; adv_n = a; addr_i = ad; il = m; wreq = w;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst = 1; sp_n = 1; sc_n = 1; adv_n = 1; e1_n = 0; e2 = 1; e3_n = 0;
    il = 1; wreq = 0; addr_i = '0;
    @(negedge clk);
    drive(1, 1, 1, 1, '0, 1, 0);              // R1 reset state
    drive(0, 1, 1, 0, '0, 1, 0);              // R11 advance while idle
    // R7 R8 R9: every base offset, both orders, past the wrap
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 4; b++) begin
        drive(0, 0, 1, 1, AW'(8'h28 | b), m[0], 1);   // R2 read despite wr_req
        for (int k = 0; k < 6; k++) drive(0, 1, 1, 0, '0, m[0], k[0]);
        drive(0, 1, 1, 1, '0, m[0], 1);        // R10 suspend
        drive(0, 1, 1, 0, '0, m[0], 0);
      end
    end
    // R4 controller load as write, R3 both strobes
    drive(0, 1, 0, 1, 6'h13, 0, 1);
    drive(0, 0, 0, 1, 6'h2e, 0, 1);
    // R5 controller strobe with en2 low, then R11
    e2 = 0; drive(0, 1, 0, 0, 6'h05, 0, 1); e2 = 1;
    drive(0, 1, 1, 0, '0, 0, 0);
    // R6 processor strobe with en1_n high is ignored
    drive(0, 1, 0, 1, 6'h31, 1, 0);
    e1_n = 1; drive(0, 0, 1, 0, 6'h0a, 1, 0); e1_n = 0;
    // pseudo-random mix
    r = 32'h1d2c3b4a;
    for (int i = 0; i < 4000; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      e1_n = r[5] & r[6];
      e2   = r[7] | r[8];
      e3_n = r[9] & r[10];
      drive(r[20:17] == 4'h0, r[0] | r[1], r[2] | r[3], r[4],
            r[18+:AW], r[11], r[12]);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule